// File: doc/BRIEF.md
# Self-Synchronizing PRBS Error Checker

This block checks a serial pseudo-random bit stream that arrives one bit per clock, qualified by a valid strobe. It makes no search for the stream's phase. It fills a local 7-stage linear feedback shift register directly from the received bits. From then on that register runs on its own feedback and predicts every following bit. Each received bit is compared with the prediction, and any difference counts as a bit error.

A small state machine moves through four states: idle, seeding, a verification run that must be error-free, and locked. In the locked state it counts received bits and bit errors. It drops lock and reseeds when errors in a sliding window exceed a limit. Driving the enable input low stops all counting and returns the machine to idle. A synchronous clear input zeroes both counters.

Top module: `prbs_sync_checker`

## Requirements
- R1: After reset, `locked` is 0 and `bit_cnt` and `err_cnt` are both 0.
- R2: The pattern obeys b[t] = b[t-7] XOR b[t-6], which is the polynomial x^7 + x^6 + 1. The stream has period 127. Once enabled, the checker needs one idle cycle and then takes the next 7 valid bits as its seed. It then checks 32 further valid bits. If all 32 match, `locked` is 1 after the clock edge of the 39th valid bit.
- R3: A seed of all zeros is rejected. The block stays in seeding and takes the next 7 valid bits as a new seed.
- R4: A mismatch during the 32-bit verification run sends the block back to seeding. That mismatched bit is not used as a seed bit.
- R5: `bit_cnt` increments by one for each valid bit received while locked, and for no other bit. The bit on whose edge lock is gained is not counted.
- R6: While locked, `err_cnt` increments by one for each valid bit that differs from the prediction. The local register keeps running on its own feedback, so a corrupted bit does not affect later predictions.
- R7: While locked, a record is kept of the most recent 64 checked bits. When a bit error brings the error total within that window above 8, `locked` falls on that bit's edge and seeding restarts. A total of exactly 8 keeps the lock.
- R8: While `en` is 0, the block goes to idle, `locked` is 0 from the next edge, and both counters hold their values.
- R9: `clr` high at a clock edge sets both counters to 0 on that edge. This takes priority over counting.
- R10: Both counters saturate at all ones. Their width is the parameter `CNT_W`, which defaults to 32.
- R11: A clock with `din_vld` low advances nothing. No prediction, seed, verification or count step takes place, whatever value `din` has.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Checker enable; low returns the machine to idle |
| clr | input | 1 | Synchronous clear of both counters |
| din | input | 1 | Received serial bit |
| din_vld | input | 1 | Qualifies `din` on this clock |
| locked | output | 1 | Checker is synchronized and counting |
| bit_cnt | output | CNT_W | Valid bits checked while locked, saturating |
| err_cnt | output | CNT_W | Bit errors seen while locked, saturating |

## Verification
Some properties are checked by assertions on every cycle. These are: counters hold outside the locked state, counters saturate, `clr` clears both counters, the error count never rises by more than one per clock, `locked` falls after `en` goes low, the window total never exceeds the window length, and the register is never all zero in the verification state. Other behaviour can only be shown by the bench's scenarios. The exact lock latency is swept over all 127 stream phases. The bench also covers rejection of an all-zero seed, reseeding after a verification error, the 8-versus-9 error boundary of the sliding window, stalls on the valid strobe, and saturation. Saturation is shown on a second instance with 4-bit counters.

// File: rtl/prbs_sync_checker.sv
module prbs_sync_checker #(
  parameter int LFSR_W     = 7,
  parameter int TAP_B      = 6,
  parameter int VERIFY_LEN = 32,
  parameter int WIN_LEN    = 64,
  parameter int ERR_LIMIT  = 8,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             din,
  input  logic             din_vld,
  output logic             locked,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [CNT_W-1:0] err_cnt
);

  localparam int SEED_CW = $clog2(LFSR_W + 1);
  localparam int VER_CW  = $clog2(VERIFY_LEN + 1);
  localparam int SUM_W   = $clog2(WIN_LEN + 1) + 1;
  localparam logic [CNT_W-1:0] ONE = 1;

  typedef enum logic [1:0] {S_IDLE, S_SEED, S_VERIFY, S_LOCK} st_t;

  st_t                st;
  logic [LFSR_W-1:0]  sr;
  logic [SEED_CW-1:0] seed_cnt;
  logic [VER_CW-1:0]  ver_cnt;
  logic [WIN_LEN-1:0] win;
  logic [SUM_W-1:0]   win_sum;

  wire               pred     = sr[LFSR_W-1] ^ sr[TAP_B-1];
  wire               miss     = din ^ pred;
  wire [LFSR_W-1:0]  seed_new = {sr[LFSR_W-2:0], din};
  wire [LFSR_W-1:0]  run_new  = {sr[LFSR_W-2:0], pred};
  wire [SUM_W-1:0]   sum_nxt  = win_sum + SUM_W'(miss) - SUM_W'(win[WIN_LEN-1]);
  wire               count_en = en && (st == S_LOCK) && din_vld;

  assign locked = (st == S_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sr       <= '0;
      seed_cnt <= '0;
      ver_cnt  <= '0;
      win      <= '0;
      win_sum  <= '0;
    end else if (!en) begin
      st       <= S_IDLE;
      seed_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st       <= S_SEED;
          seed_cnt <= '0;
        end
        S_SEED: if (din_vld) begin
          sr <= seed_new;
          if (seed_cnt == SEED_CW'(LFSR_W - 1)) begin
            seed_cnt <= '0;
            if (seed_new != '0) begin
              st      <= S_VERIFY;
              ver_cnt <= '0;
            end
          end else begin
            seed_cnt <= seed_cnt + 1'b1;
          end
        end
        S_VERIFY: if (din_vld) begin
          sr <= run_new;
          if (miss) begin
            st       <= S_SEED;
            seed_cnt <= '0;
          end else if (ver_cnt == VER_CW'(VERIFY_LEN - 1)) begin
            st      <= S_LOCK;
            win     <= '0;
            win_sum <= '0;
          end else begin
            ver_cnt <= ver_cnt + 1'b1;
          end
        end
        S_LOCK: if (din_vld) begin
          sr      <= run_new;
          win     <= {win[WIN_LEN-2:0], miss};
          win_sum <= sum_nxt;
          if (sum_nxt > SUM_W'(ERR_LIMIT)) begin
            st       <= S_SEED;
            seed_cnt <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (clr) begin
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (count_en) begin
      if (bit_cnt != '1) bit_cnt <= bit_cnt + ONE;
      if (miss && err_cnt != '1) err_cnt <= err_cnt + ONE;
    end
  end

  a_r5_hold_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_LOCK && !clr) |=> ($stable(bit_cnt) && $stable(err_cnt)));

  a_r10_bit_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == '1 && !clr) |=> (bit_cnt == '1));

  a_r10_err_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == '1 && !clr) |=> (err_cnt == '1));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bit_cnt == '0 && err_cnt == '0));

  a_r6_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + ONE));

  a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !locked);

  a_r7_win_bound: assert property (@(posedge clk) disable iff (!rst_n)
    win_sum <= SUM_W'(WIN_LEN));

  a_r3_nonzero_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_VERIFY) |-> (sr != '0));

endmodule

// File: tb/tb_prbs_sync_checker.sv
module tb_prbs_sync_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic clr = 1'b0;
  logic din = 1'b0;
  logic din_vld = 1'b0;
  logic locked, locked_s;
  logic [31:0] bit_cnt, err_cnt;
  logic [3:0] bc_s, ec_s;
  logic [6:0] tx;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prbs_sync_checker dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .din(din), .din_vld(din_vld),
    .locked(locked), .bit_cnt(bit_cnt), .err_cnt(err_cnt));

  prbs_sync_checker #(.CNT_W(4)) dut_s (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .din(din), .din_vld(din_vld),
    .locked(locked_s), .bit_cnt(bc_s), .err_cnt(ec_s));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic v);
    din = b;
    din_vld = v;
    @(negedge clk);
  endtask

  task automatic prbs(input int n);
    for (int i = 0; i < n; i++) begin
      logic nb;
      nb = tx[6] ^ tx[5];
      tx = {tx[5:0], nb};
      step(nb, 1'b1);
    end
  endtask

  task automatic bad();
    logic nb;
    nb = tx[6] ^ tx[5];
    tx = {tx[5:0], nb};
    step(~nb, 1'b1);
  endtask

  task automatic restart();
    en = 1'b0;
    step(1'b0, 1'b0);
    en = 1'b1;
    clr = 1'b1;
    step(1'b0, 1'b0);
    clr = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    check("R1 locked", locked, 0);
    check("R1 bit_cnt", bit_cnt, 0);
    check("R1 err_cnt", err_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 1; s < 128; s++) begin
      restart();
      tx = 7'(s);
      prbs(38);
      check("R2 not yet locked", locked, 0);
      prbs(1);
      check("R2 locked at 39", locked, 1);
      check("R5 lock bit uncounted", bit_cnt, 0);
      prbs(20);
      check("R5 bit_cnt", bit_cnt, 20);
      check("R6 no errors", err_cnt, 0);
    end

    restart();
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1);
    tx = 7'h15;
    prbs(38);
    check("R3 zero seed rejected", locked, 0);
    prbs(1);
    check("R3 lock after reseed", locked, 1);

    restart();
    tx = 7'h4c;
    prbs(20);
    bad();
    prbs(38);
    check("R4 reseed after verify error", locked, 0);
    prbs(1);
    check("R4 lock after reseed", locked, 1);

    clr = 1'b1; step(1'b0, 1'b0); clr = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (i == 10 || i == 30 || i == 50) bad(); else prbs(1);
    end
    check("R6 err_cnt", err_cnt, 3);
    check("R5 bit_cnt locked", bit_cnt, 100);
    check("R6 lock kept", locked, 1);

    restart();
    tx = 7'h33;
    prbs(39);
    for (int i = 0; i < 8; i++) bad();
    check("R7 8 errors keep lock", locked, 1);
    prbs(56);
    bad();
    check("R7 oldest error leaves window", locked, 1);
    check("R6 err_cnt 9", err_cnt, 9);

    restart();
    tx = 7'h01;
    prbs(39);
    for (int i = 0; i < 8; i++) bad();
    check("R7 at limit", locked, 1);
    bad();
    check("R7 ninth error drops lock", locked, 0);
    check("R7 err counted", err_cnt, 9);
    prbs(5);
    check("R7 no count after drop", bit_cnt, 9);

    restart();
    tx = 7'h2a;
    prbs(39);
    for (int i = 0; i < 30; i++) begin
      step(1'(i % 3 == 0), 1'b0);
      prbs(1);
    end
    check("R11 stalls ignored bit_cnt", bit_cnt, 30);
    check("R11 stalls ignored err_cnt", err_cnt, 0);
    check("R11 lock kept", locked, 1);

    en = 1'b0;
    step(1'b0, 1'b0);
    check("R8 disable drops lock", locked, 0);
    prbs(10);
    check("R8 bit_cnt holds", bit_cnt, 30);
    check("R8 err_cnt holds", err_cnt, 0);

    clr = 1'b1;
    step(1'b0, 1'b0);
    clr = 1'b0;
    check("R9 clr bit_cnt", bit_cnt, 0);

    restart();
    tx = 7'h7f;
    prbs(39);
    prbs(20);
    check("R10 bit_cnt saturates", bc_s, 15);
    check("R10 wide counter", bit_cnt, 20);
    for (int i = 0; i < 20; i++) begin
      if (i % 10 == 0) bad(); else prbs(1);
    end
    check("R10 sat holds", bc_s, 15);
    check("R6 err_cnt small", ec_s, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule